// File: doc/BRIEF.md
# NIC Interrupt Moderation Controller

This block gathers interrupt causes for a network controller and decides when its single interrupt line goes high. Any unit of the controller may post a vector of cause bits. The bits collect in a pending register and are gated by an enable mask. Four delay timers hold back completion notices. Two of them serve receive and two serve transmit, and each direction has a packet timer and an absolute timer. When one of these timers expires, the block asks for a descriptor writeback and posts that direction's cause bit.

A throttle timer limits how often the line can rise. Causes that arrive while the throttle window is open stay in the pending register. When the window closes, they produce one assertion. A post flagged as immediate skips the throttle. Software reads and writes seven registers through a simple register port. Reading the pending register returns its contents, clears it, and takes the line low.

All timers count ticks of a prescaler. One tick equals 1024 ns, which is `TICK_CYCLES` clocks (128 at 125 MHz).

Top module: `nic_irq_moderator`

## Requirements
- R1: A cycle with `postValid` high ORs `postCause` into the pending register at the next edge. A read at address 0 returns the pending bits, zero-extended, on `regRdData` one cycle after `regRdEn`.
- R2: `irq` rises only when some pending bit is also set in the mask register (address 1, bit i enables cause i). With the throttle idle, it rises one cycle after the pending-and-mask product becomes nonzero.
- R3: A read of address 0 clears the pending register and drives `irq` low at the same edge. Cause bits posted in that same cycle are kept.
- R4: A mask write re-evaluates the pending causes. Unmasking a pending cause raises `irq`. If no enabled cause remains, `irq` drops one cycle after the mask register updates.
- R5: The packet delay timers (receive at address 2, transmit at address 4) reload their value on every event. After the last event they expire after the programmed number of ticks.
- R6: The absolute delay timers (receive at address 3, transmit at address 5) load on the first event while idle. Further events do not restart them until they expire.
- R7: Expiry of either receive timer gives a one-cycle `rxWbReq` pulse and sets pending bit `RXT_BIT` (default 7). Expiry of either transmit timer gives a one-cycle `txWbReq` pulse and sets pending bit `TXDW_BIT` (default 0).
- R8: One timer tick is produced every `TICK_CYCLES` clocks after reset. Delay and throttle values count these ticks.
- R9: A delay timer programmed with zero never starts and never expires.
- R10: Each assertion of `irq` opens a throttle window of the number of ticks at address 6 (zero means no window). Inside the window no new assertion happens. Causes accumulate, and one assertion follows when the window ends.
- R11: A post with `postNow` high lets the following assertion bypass an open throttle window.
- R12: Writes to address 0 are ignored. Reads of address 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postValid | input | 1 | Cause post strobe |
| postCause | input | NCAUSE | Cause bits to post |
| postNow | input | 1 | Post bypasses the throttle |
| rxEvent | input | 1 | Receive event that starts the receive delay timers |
| txEvent | input | 1 | Transmit event that starts the transmit delay timers |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | AW | Register address |
| regWrData | input | DW | Register write data |
| regRdData | output | DW | Registered read data |
| rxWbReq | output | 1 | Receive descriptor writeback request |
| txWbReq | output | 1 | Transmit descriptor writeback request |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker tests a set of rules on every cycle. Each rising edge of the line must follow an enabled pending cause. A pending read must leave the line low and keep only same-cycle causes. Every writeback pulse must lie inside the pending register as its matching cause bit, and must last a single cycle. Restart rules for the packet and absolute timers, the spacing of throttled assertions, the immediate bypass and the zero-value disable span many ticks. Only the bench can show these, by comparing against its behavioural model and counting pulses and rising edges over whole scenarios.

// File: rtl/imod_pkg.sv
package imod_pkg;
  localparam int ADDR_PEND = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_CFG0 = 2;
  localparam int NCFG      = 5;   // rxPkt, rxAbs, txPkt, txAbs, throttle
  localparam int CFG_THR   = 4;

  typedef struct packed {
    logic            clrPend;
    logic            wrMask;
    logic [NCFG-1:0] wrCfg;
    logic            rdLoad;
  } imodStrobe_t;
endpackage

// File: rtl/imod_timer.sv
module imod_timer #(
  parameter int TW       = 16,
  parameter bit ABSOLUTE = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cfg,
  input  logic          start,
  input  logic          tick,
  output logic          fire
);
  logic [TW-1:0] cntQ;
  logic          actQ;
  logic          enabled;
  logic          restart;

  assign enabled = (cfg != '0);
  assign restart = start && (!ABSOLUTE || !actQ);
  assign fire    = enabled && actQ && tick && (cntQ == TW'(1)) && !(start && !ABSOLUTE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      actQ <= 1'b0;
    end else if (!enabled) begin
      actQ <= 1'b0;
    end else if (restart) begin
      cntQ <= cfg;
      actQ <= 1'b1;
    end else if (actQ && tick) begin
      actQ <= (cntQ > TW'(1));
      cntQ <= cntQ - TW'(1);
    end
  end
endmodule

// File: rtl/imod_datapath.sv
module imod_datapath import imod_pkg::*; #(
  parameter int NCAUSE      = 8,
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int TW          = 16,
  parameter int TICK_CYCLES = 128,
  parameter int RXT_BIT     = 7,
  parameter int TXDW_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  imodStrobe_t       strb,
  input  logic [AW-1:0]     regAddr,
  input  logic [DW-1:0]     regWrData,
  input  logic              postValid,
  input  logic [NCAUSE-1:0] postCause,
  input  logic              rxEvent,
  input  logic              txEvent,
  output logic              tick,
  output logic              want,
  output logic [TW-1:0]     thrCfg,
  output logic [NCAUSE-1:0] pendQ,
  output logic [NCAUSE-1:0] maskQ,
  output logic [DW-1:0]     regRdData,
  output logic              rxWbReq,
  output logic              txWbReq
);
  localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam int NTIMER = 4;

  logic [PW-1:0]     preQ;
  logic [TW-1:0]     cfgQ [NCFG];
  logic [NTIMER-1:0] fireVec;
  logic              rxFire, txFire;
  logic [NCAUSE-1:0] setBits;
  logic [DW-1:0]     rdMux;

  // prescaler: one tick per 1024 ns
  assign tick = (preQ == PW'(TICK_CYCLES - 1));
  always_ff @(posedge clk) begin
    if (!rstN)     preQ <= '0;
    else if (tick) preQ <= '0;
    else           preQ <= preQ + PW'(1);
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCFG; c++) cfgQ[c] <= '0;
      maskQ <= '0;
    end else begin
      for (int c = 0; c < NCFG; c++)
        if (strb.wrCfg[c]) cfgQ[c] <= regWrData[TW-1:0];
      if (strb.wrMask) maskQ <= regWrData[NCAUSE-1:0];
    end
  end
  assign thrCfg = cfgQ[CFG_THR];

  // delay timers: even index = packet, odd index = absolute
  for (genvar t = 0; t < NTIMER; t++) begin : g_timer
    imod_timer #(.TW(TW), .ABSOLUTE(t % 2 == 1)) u_timer (
      .clk  (clk),
      .rstN (rstN),
      .cfg  (cfgQ[t]),
      .start((t < 2) ? rxEvent : txEvent),
      .tick (tick),
      .fire (fireVec[t])
    );
  end
  assign rxFire = fireVec[0] | fireVec[1];
  assign txFire = fireVec[2] | fireVec[3];

  // pending register
  always_comb begin
    setBits = postValid ? postCause : '0;
    setBits[RXT_BIT]  = setBits[RXT_BIT]  | rxFire;
    setBits[TXDW_BIT] = setBits[TXDW_BIT] | txFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      rxWbReq <= 1'b0;
      txWbReq <= 1'b0;
    end else begin
      pendQ   <= (strb.clrPend ? '0 : pendQ) | setBits;
      rxWbReq <= rxFire;
      txWbReq <= txFire;
    end
  end
  assign want = |(pendQ & maskQ);

  // read path
  always_comb begin
    rdMux = '0;
    if (int'(regAddr) == ADDR_PEND)      rdMux = DW'(pendQ);
    else if (int'(regAddr) == ADDR_MASK) rdMux = DW'(maskQ);
    else begin
      for (int c = 0; c < NCFG; c++)
        if (int'(regAddr) == ADDR_CFG0 + c) rdMux = DW'(cfgQ[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            regRdData <= '0;
    else if (strb.rdLoad) regRdData <= rdMux;
  end
endmodule

// File: rtl/imod_control.sv
module imod_control import imod_pkg::*; #(
  parameter int AW = 3,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic          postValid,
  input  logic          postNow,
  input  logic          want,
  input  logic          tick,
  input  logic [TW-1:0] thrCfg,
  output imodStrobe_t   strb,
  output logic          irq
);
  logic          thrActQ;
  logic [TW-1:0] thrCntQ;
  logic          nowQ;
  logic          newNow;
  logic          assertGo;

  // register access decode
  always_comb begin
    strb         = '0;
    strb.rdLoad  = regRdEn;
    strb.clrPend = regRdEn && (int'(regAddr) == ADDR_PEND);
    strb.wrMask  = regWrEn && (int'(regAddr) == ADDR_MASK);
    for (int c = 0; c < NCFG; c++)
      strb.wrCfg[c] = regWrEn && (int'(regAddr) == ADDR_CFG0 + c);
  end

  assign newNow   = postValid && postNow;
  assign assertGo = !irq && want && (!thrActQ || nowQ) && !strb.clrPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq     <= 1'b0;
      thrActQ <= 1'b0;
      thrCntQ <= '0;
      nowQ    <= 1'b0;
    end else begin
      if (strb.clrPend)     irq <= 1'b0;
      else if (irq && !want) irq <= 1'b0;
      else if (assertGo)    irq <= 1'b1;

      if (assertGo) begin
        thrActQ <= (thrCfg != '0);
        thrCntQ <= thrCfg;
      end else if (thrActQ && tick) begin
        thrActQ <= (thrCntQ > TW'(1));
        thrCntQ <= thrCntQ - TW'(1);
      end

      if (assertGo || strb.clrPend) nowQ <= newNow;
      else                          nowQ <= nowQ | newNow;
    end
  end
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator import imod_pkg::*; #(
  parameter int NCAUSE      = 8,
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int TW          = 16,
  parameter int TICK_CYCLES = 128,
  parameter int RXT_BIT     = 7,
  parameter int TXDW_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic [NCAUSE-1:0] postCause,
  input  logic              postNow,
  input  logic              rxEvent,
  input  logic              txEvent,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [AW-1:0]     regAddr,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output logic              rxWbReq,
  output logic              txWbReq,
  output logic              irq
);
  imodStrobe_t       strb;
  logic              tick;
  logic              want;
  logic [TW-1:0]     thrCfg;
  logic [NCAUSE-1:0] pendQ;
  logic [NCAUSE-1:0] maskQ;

  imod_control #(.AW(AW), .TW(TW)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .postValid(postValid), .postNow(postNow),
    .want(want), .tick(tick), .thrCfg(thrCfg), .strb(strb), .irq(irq)
  );

  imod_datapath #(
    .NCAUSE(NCAUSE), .DW(DW), .AW(AW), .TW(TW), .TICK_CYCLES(TICK_CYCLES),
    .RXT_BIT(RXT_BIT), .TXDW_BIT(TXDW_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .postValid(postValid), .postCause(postCause),
    .rxEvent(rxEvent), .txEvent(txEvent), .tick(tick), .want(want),
    .thrCfg(thrCfg), .pendQ(pendQ), .maskQ(maskQ), .regRdData(regRdData),
    .rxWbReq(rxWbReq), .txWbReq(txWbReq)
  );
endmodule

// File: rtl/nic_irq_moderator_chk.sv
module nic_irq_moderator_chk #(
  parameter int NCAUSE   = 8,
  parameter int AW       = 3,
  parameter int RXT_BIT  = 7,
  parameter int TXDW_BIT = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [AW-1:0]     regAddr,
  input logic              postValid,
  input logic [NCAUSE-1:0] postCause,
  input logic              irq,
  input logic [NCAUSE-1:0] pendQ,
  input logic [NCAUSE-1:0] maskQ,
  input logic              rxWbReq,
  input logic              txWbReq
);
  localparam logic [NCAUSE-1:0] TIMER_BITS =
    (NCAUSE'(1) << RXT_BIT) | (NCAUSE'(1) << TXDW_BIT);

  logic pendRead;
  assign pendRead = regRdEn && (regAddr == '0);

  p_rise_needs_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|(pendQ & maskQ)));

  p_read_drops_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    pendRead |=> !irq);

  p_read_clears_pend_r3: assert property (@(posedge clk) disable iff (!rstN)
    pendRead |=> ((pendQ & ~$past(postValid ? postCause : '0) & ~TIMER_BITS) == '0));

  p_rx_wb_posts_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxWbReq |-> pendQ[RXT_BIT]);

  p_tx_wb_posts_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    txWbReq |-> pendQ[TXDW_BIT]);

  p_rx_wb_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxWbReq |=> !rxWbReq);

  p_tx_wb_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    txWbReq |=> !txWbReq);
endmodule

bind nic_irq_moderator nic_irq_moderator_chk #(
  .NCAUSE(NCAUSE), .AW(AW), .RXT_BIT(RXT_BIT), .TXDW_BIT(TXDW_BIT)
) i_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
  .postValid(postValid), .postCause(postCause), .irq(irq),
  .pendQ(pendQ), .maskQ(maskQ), .rxWbReq(rxWbReq), .txWbReq(txWbReq)
);

// File: tb/test_nic_irq_moderator.sv
module test_nic_irq_moderator;
  localparam int NC = 8, DW = 16, AW = 3, TW = 16, TC = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic postValid = 0, postNow = 0, rxEvent = 0, txEvent = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [NC-1:0] postCause = '0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic rxWbReq, txWbReq, irq;

  always #4 clk = ~clk;

  nic_irq_moderator #(.NCAUSE(NC), .DW(DW), .AW(AW), .TW(TW), .TICK_CYCLES(TC))
    i_nic_irq_moderator (.*);

  int vectors = 0, fails = 0, cycles = 0;
  int rxPulses = 0, txPulses = 0, irqRises = 0;
  string curReq = "R1";

  // behavioural reference model
  logic [NC-1:0] mPend, mMask;
  int  mCfg [5];
  int  mCnt [4];
  bit  mAct [4];
  int  mPre, mThrCnt;
  bit  mIrq, mThrAct, mNow, mRxWb, mTxWb;
  logic [DW-1:0] mRd;

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mMask = '0; mPre = 0; mThrCnt = 0;
      mIrq = 0; mThrAct = 0; mNow = 0; mRxWb = 0; mTxWb = 0; mRd = '0;
      for (int i = 0; i < 5; i++) mCfg[i] = 0;
      for (int i = 0; i < 4; i++) begin mCnt[i] = 0; mAct[i] = 0; end
    end else begin
      bit tk, clr, want, go, rxF, txF, ev, isAbs;
      bit f [4];
      logic [NC-1:0] setB;
      logic [DW-1:0] rdv;
      tk = (mPre == TC - 1);
      for (int i = 0; i < 4; i++) begin
        ev = (i < 2) ? rxEvent : txEvent;
        isAbs = (i % 2 == 1);
        f[i] = (mCfg[i] != 0) && mAct[i] && tk && (mCnt[i] == 1) && !(ev && !isAbs);
      end
      rxF = f[0] || f[1];
      txF = f[2] || f[3];
      setB = postValid ? postCause : '0;
      if (rxF) setB[7] = 1'b1;
      if (txF) setB[0] = 1'b1;
      clr  = regRdEn && (regAddr == 0);
      want = (mPend & mMask) != 0;
      go   = !mIrq && want && (!mThrAct || mNow) && !clr;
      case (int'(regAddr))
        0: rdv = DW'(mPend);
        1: rdv = DW'(mMask);
        2, 3, 4, 5, 6: rdv = DW'(mCfg[int'(regAddr) - 2]);
        default: rdv = '0;
      endcase
      // timers
      for (int i = 0; i < 4; i++) begin
        ev = (i < 2) ? rxEvent : txEvent;
        isAbs = (i % 2 == 1);
        if (mCfg[i] == 0) mAct[i] = 0;
        else if (ev && (!isAbs || !mAct[i])) begin mCnt[i] = mCfg[i]; mAct[i] = 1; end
        else if (mAct[i] && tk) begin mAct[i] = (mCnt[i] > 1); mCnt[i] = mCnt[i] - 1; end
      end
      // throttle and now flag
      if (go) begin mThrAct = (mCfg[4] != 0); mThrCnt = mCfg[4]; end
      else if (mThrAct && tk) begin mThrAct = (mThrCnt > 1); mThrCnt = mThrCnt - 1; end
      if (go || clr) mNow = postValid && postNow;
      else mNow = mNow || (postValid && postNow);
      if (clr) mIrq = 0;
      else if (mIrq && !want) mIrq = 0;
      else if (go) mIrq = 1;
      mPend = (clr ? '0 : mPend) | setB;
      mRxWb = rxF; mTxWb = txF;
      if (regRdEn) mRd = rdv;
      if (regWrEn && regAddr == 1) mMask = regWrData[NC-1:0];
      if (regWrEn && regAddr >= 2 && regAddr <= 6) mCfg[int'(regAddr) - 2] = int'(regWrData);
      mPre = tk ? 0 : mPre + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // per-clock comparison, sampled at the falling edge
  bit irqPrev = 0;
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(curReq, "irq", irq, mIrq);
      check(curReq, "rxWbReq", rxWbReq, mRxWb);
      check(curReq, "txWbReq", txWbReq, mTxWb);
      check(curReq, "regRdData", regRdData, mRd);
      if (rxWbReq) rxPulses++;
      if (txWbReq) txPulses++;
      if (irq && !irqPrev) irqRises++;
      irqPrev = irq;
    end
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    regWrEn = 1; regAddr = AW'(a); regWrData = DW'(d);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input int a, output int v);
    regRdEn = 1; regAddr = AW'(a);
    @(negedge clk);
    regRdEn = 0;
    @(negedge clk);
    v = int'(regRdData);
  endtask

  task automatic post(input int c, input bit now);
    postValid = 1; postCause = NC'(c); postNow = now;
    @(negedge clk);
    postValid = 0; postNow = 0; postCause = '0;
  endtask

  initial begin
    int v;
    int r0;
    idle(3);
    rstN = 1;
    @(negedge clk);
    check("R1", "reset irq", irq, 0);
    check("R1", "reset rdData", regRdData, 0);

    // R1 R2: masked cause does not raise the line
    curReq = "R2";
    post(32'h04, 0);
    idle(3);
    check("R2", "masked irq", irq, 0);
    curReq = "R1";
    rd(0, v);
    check("R1", "pending read", v, 32'h04);
    rd(0, v);
    check("R3", "pending cleared", v, 0);

    // R12: write to pending ignored, address 7 reads zero
    curReq = "R12";
    wr(0, 32'hFF);
    rd(0, v);
    check("R12", "pending write ignored", v, 0);
    rd(7, v);
    check("R12", "addr 7", v, 0);

    // R2 R3
    curReq = "R2";
    wr(1, 32'hFF);
    rd(1, v);
    check("R2", "mask readback", v, 32'hFF);
    post(32'h02, 0);
    @(negedge clk);
    check("R2", "irq rises", irq, 1);
    curReq = "R3";
    regRdEn = 1; regAddr = 0; postValid = 1; postCause = 8'h20;
    @(negedge clk);
    regRdEn = 0; postValid = 0; postCause = '0;
    check("R3", "irq dropped by read", irq, 0);
    check("R3", "read data", regRdData, 32'h02);
    rd(0, v);
    check("R3", "same-cycle post kept", v, 32'h20);
    idle(2);

    // R4: mask re-evaluation
    curReq = "R4";
    wr(1, 0);
    post(32'h08, 0);
    idle(2);
    check("R4", "masked stays low", irq, 0);
    wr(1, 32'h08);
    @(negedge clk);
    check("R4", "unmask raises", irq, 1);
    wr(1, 32'h01);
    @(negedge clk);
    check("R4", "mask drop", irq, 0);
    rd(0, v);
    wr(1, 0);

    // R5 R8: receive packet timer restarts
    curReq = "R5";
    wr(2, 3);
    r0 = rxPulses;
    for (int k = 0; k < 5; k++) begin
      rxEvent = 1; @(negedge clk); rxEvent = 0; idle(5);
    end
    check("R5", "no expiry while restarting", rxPulses - r0, 0);
    idle(20);
    check("R5", "single rx expiry", rxPulses - r0, 1);
    curReq = "R7";
    rd(0, v);
    check("R7", "rx cause bit 7", v, 32'h80);
    wr(2, 0);

    // R6: absolute timer fires despite continuous events
    curReq = "R6";
    wr(3, 5);
    r0 = rxPulses;
    for (int k = 0; k < 10; k++) begin
      rxEvent = 1; @(negedge clk); rxEvent = 0; idle(5);
    end
    check("R6", "absolute expiries >= 2", (rxPulses - r0) >= 2, 1);
    wr(3, 0);
    idle(30);
    rd(0, v);

    // R7: transmit timers
    curReq = "R7";
    wr(4, 2);
    r0 = txPulses;
    txEvent = 1; @(negedge clk); txEvent = 0;
    idle(15);
    check("R7", "tx expiry", txPulses - r0, 1);
    rd(0, v);
    check("R7", "tx cause bit 0", v, 32'h01);
    wr(4, 0);
    wr(5, 2);
    r0 = txPulses;
    txEvent = 1; @(negedge clk); txEvent = 0;
    idle(15);
    check("R6", "tx absolute expiry", txPulses - r0, 1);
    wr(5, 0);
    rd(0, v);

    // R9: zero disables
    curReq = "R9";
    r0 = rxPulses + txPulses;
    for (int k = 0; k < 3; k++) begin
      rxEvent = 1; txEvent = 1; @(negedge clk); rxEvent = 0; txEvent = 0; idle(6);
    end
    idle(20);
    check("R9", "no expiry when zero", rxPulses + txPulses - r0, 0);

    // R10: throttle
    curReq = "R10";
    wr(6, 10);
    wr(1, 32'hFF);
    r0 = irqRises;
    post(32'h02, 0);
    @(negedge clk);
    check("R10", "first assertion", irq, 1);
    rd(0, v);
    post(32'h04, 0);
    idle(4);
    post(32'h10, 0);
    idle(4);
    check("R10", "held in window", irq, 0);
    idle(40);
    check("R10", "one assertion after window", irqRises - r0, 2);
    check("R10", "line high after window", irq, 1);
    rd(0, v);
    check("R10", "accumulated causes", v, 32'h14);

    // R11: immediate post bypasses throttle window
    curReq = "R11";
    idle(2);
    post(32'h40, 1);
    @(negedge clk);
    check("R11", "immediate bypass", irq, 1);
    rd(0, v);
    idle(50);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule